// File: doc/BRIEF.md
# Serial Board Command Decoder

This block receives 24-bit command words over a two-wire synchronous serial link (a serial clock and a data line) plus a frame line that realigns word boundaries. The same word is broadcast to every video board, so every board decodes it the same way. A 4-bit function field in bits 19..16 selects which register the word updates. Value 0xD writes a 4-bit amplifier gain code, and value 0xC writes the board options. Any other function value is ignored.

The options word sets three level outputs: the fast-conversion (WARP) enable, the half-word select, and the bias DAC output enable. An options word with bit 3 set also produces a self-timed clear strobe for the image data FIFO, and it still writes the three option bits. Gain code 15 is not a legal setting. It is rejected and flagged instead of being stored. All three serial inputs are resynchronised to the system clock, and bits are taken on rising edges of the serial clock.

Top module: `sercmd_decoder`

## Requirements
- R1: After reset, gainCode is 0, warpEn, lowHalfSel and dacEn are 0, and fifoClr and gainErr are low.
- R2: Bits are taken MSB first on each rising edge of serClk while serFrame is low. After 24 bits a word is complete. A word whose bits 19..16 equal 0xD loads bits 3..0 into gainCode.
- R3: A gain word carrying code 15 (0xF) leaves gainCode unchanged and raises gainErr for exactly one system clock cycle.
- R4: A word whose bits 19..16 equal 0xC overwrites all three option outputs at once: bit 0 goes to warpEn, bit 1 goes to lowHalfSel (1 = low 16 bits of the result), and bit 2 goes to dacEn.
- R5: An options word with bit 3 set drives fifoClr high for exactly 4 consecutive system clock cycles, and it still writes bits 2..0 to the option outputs.
- R6: A complete word whose function field is neither 0xC nor 0xD changes no output.
- R7: serFrame high clears the bit position. A partial word received before it is discarded, and the next 24 bits form a new word.
- R8: Bits 23..20 and 15..4 of a gain word have no effect on the stored gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| serClk | input | 1 | Serial clock; data is taken on its rising edge |
| serData | input | 1 | Serial data, MSB first |
| serFrame | input | 1 | High to reset the bit position |
| gainCode | output | 4 | Stored gain code |
| warpEn | output | 1 | Fast-conversion mode enable |
| lowHalfSel | output | 1 | 1 selects the low 16 result bits |
| dacEn | output | 1 | Bias DAC output enable |
| fifoClr | output | 1 | Image FIFO clear strobe, 4 cycles long |
| gainErr | output | 1 | One-cycle flag for a rejected gain code |

## Verification
The hardest case to reach from the ports is a bit counter that is out of step with the word boundary. To get there, the bench shifts in ten stray bits and then raises the frame line. It then sends a full gain word and checks that the word decodes cleanly, which it would not do if the stray bits were still counted. The clear pulse is over before the outputs settle after a word, so a monitor counts the cycles in which the pulse is high. That count must be exactly four.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;
  localparam logic [3:0] FN_GAIN = 4'hD;
  localparam logic [3:0] FN_OPTS = 4'hC;

  typedef struct packed {
    logic shiftEn;
    logic wordDone;
    logic bitVal;
  } serStrobe_t;
endpackage

// File: rtl/sercmd_ctrl.sv
module sercmd_ctrl
  import sercmd_pkg::*;
#(
  parameter int WORD_BITS   = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serClk,
  input  logic       serData,
  input  logic       serFrame,
  output serStrobe_t strb
);
  localparam int CNT_W = $clog2(WORD_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_BITS - 1);

  // Synchronizer chain for {frame, data, clock}
  logic [2:0] syncQ [SYNC_STAGES];
  logic [2:0] rawS;
  logic       clkPrev;
  logic       rise;
  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ[0] <= '0;
    else       syncQ[0] <= {serFrame, serData, serClk};
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) syncQ[s] <= '0;
      else       syncQ[s] <= syncQ[s-1];
    end
  end

  assign rawS = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) clkPrev <= 1'b0;
    else       clkPrev <= rawS[0];
  end

  assign rise = rawS[0] & ~clkPrev;

  always_ff @(posedge clk) begin
    if (!rstN || rawS[2]) begin
      bitCnt <= '0;
    end else if (rise) begin
      if (bitCnt == LAST_BIT) bitCnt <= '0;
      else                    bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    strb.shiftEn  = rise & ~rawS[2];
    strb.wordDone = strb.shiftEn && (bitCnt == LAST_BIT);
    strb.bitVal   = rawS[1];
  end
endmodule

// File: rtl/sercmd_datapath.sv
module sercmd_datapath
  import sercmd_pkg::*;
#(
  parameter int          WORD_BITS  = 24,
  parameter int          FN_LSB     = 16,
  parameter int          GAIN_W     = 4,
  parameter int          CLR_CYCLES = 4,
  parameter logic [3:0]  GAIN_RESET = 4'd0
) (
  input  logic              clk,
  input  logic              rstN,
  input  serStrobe_t        strb,
  output logic [GAIN_W-1:0] gainCode,
  output logic              warpEn,
  output logic              lowHalfSel,
  output logic              dacEn,
  output logic              fifoClr,
  output logic              gainErr
);
  localparam int CLR_W = $clog2(CLR_CYCLES + 1);
  localparam logic [GAIN_W-1:0] GAIN_BAD = '1;

  logic [WORD_BITS-2:0] shReg;
  logic [WORD_BITS-1:0] word;
  logic [3:0]           fnSel;
  logic [CLR_W-1:0]     clrCnt;
  logic                 isGain;
  logic                 isOpts;

  assign word   = {shReg, strb.bitVal};
  assign fnSel  = word[FN_LSB +: 4];
  assign isGain = strb.wordDone && (fnSel == FN_GAIN);
  assign isOpts = strb.wordDone && (fnSel == FN_OPTS);

  always_ff @(posedge clk) begin
    if (!rstN)             shReg <= '0;
    else if (strb.shiftEn) shReg <= word[WORD_BITS-2:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gainCode <= GAIN_RESET[GAIN_W-1:0];
      gainErr  <= 1'b0;
    end else begin
      gainErr <= 1'b0;
      if (isGain) begin
        if (word[GAIN_W-1:0] == GAIN_BAD) gainErr  <= 1'b1;
        else                              gainCode <= word[GAIN_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      warpEn     <= 1'b0;
      lowHalfSel <= 1'b0;
      dacEn      <= 1'b0;
    end else if (isOpts) begin
      warpEn     <= word[0];
      lowHalfSel <= word[1];
      dacEn      <= word[2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 clrCnt <= '0;
    else if (isOpts && word[3]) clrCnt <= CLR_W'(CLR_CYCLES);
    else if (clrCnt != '0)     clrCnt <= clrCnt - 1'b1;
  end

  assign fifoClr = (clrCnt != '0);
endmodule

// File: rtl/sercmd_decoder.sv
module sercmd_decoder
  import sercmd_pkg::*;
#(
  parameter int WORD_BITS   = 24,
  parameter int SYNC_STAGES = 2,
  parameter int CLR_CYCLES  = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serClk,
  input  logic       serData,
  input  logic       serFrame,
  output logic [3:0] gainCode,
  output logic       warpEn,
  output logic       lowHalfSel,
  output logic       dacEn,
  output logic       fifoClr,
  output logic       gainErr
);
  serStrobe_t strb;

  sercmd_ctrl #(
    .WORD_BITS  (WORD_BITS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .serClk  (serClk),
    .serData (serData),
    .serFrame(serFrame),
    .strb    (strb)
  );

  sercmd_datapath #(
    .WORD_BITS (WORD_BITS),
    .FN_LSB    (16),
    .GAIN_W    (4),
    .CLR_CYCLES(CLR_CYCLES),
    .GAIN_RESET(4'd0)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .gainCode  (gainCode),
    .warpEn    (warpEn),
    .lowHalfSel(lowHalfSel),
    .dacEn     (dacEn),
    .fifoClr   (fifoClr),
    .gainErr   (gainErr)
  );
endmodule

// File: rtl/sercmd_checker.sv
module sercmd_checker #(
  parameter int CLR_CYCLES = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] gainCode,
  input logic       fifoClr,
  input logic       gainErr
);
  localparam int RUN_W = $clog2(CLR_CYCLES + 2) + 1;
  logic [RUN_W-1:0] runLen;

  always_ff @(posedge clk) begin
    if (!rstN)        runLen <= '0;
    else if (fifoClr) runLen <= runLen + 1'b1;
    else              runLen <= '0;
  end

  // R5: the pulse never outlasts its length
  p_clr_bounded_r5: assert property (@(posedge clk) disable iff (!rstN)
    fifoClr |-> (runLen < RUN_W'(CLR_CYCLES)));

  // R5: a finished pulse had its full length
  p_clr_full_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fifoClr) |-> (runLen == RUN_W'(CLR_CYCLES)));

  // R3: the error flag lasts one cycle
  p_err_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    gainErr |=> !gainErr);

  // R3: a rejected code leaves the stored gain alone
  p_err_gain_kept_r3: assert property (@(posedge clk) disable iff (!rstN)
    gainErr |-> $stable(gainCode));

  // R3: the forbidden code is never stored
  p_gain_legal_r3: assert property (@(posedge clk) disable iff (!rstN)
    gainCode != 4'hF);
endmodule

bind sercmd_decoder sercmd_checker #(.CLR_CYCLES(CLR_CYCLES)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .gainCode(gainCode),
  .fifoClr (fifoClr),
  .gainErr (gainErr)
);

// File: tb/test_sercmd_decoder.sv
`timescale 1ns/1ps
module test_sercmd_decoder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0;
  logic serData = 1'b0;
  logic serFrame = 1'b0;
  logic [3:0] gainCode;
  logic warpEn, lowHalfSel, dacEn, fifoClr, gainErr;

  int checks = 0;
  int fails = 0;
  int clrCycles = 0;
  int errCycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sercmd_decoder i_sercmd_decoder (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serFrame(serFrame), .gainCode(gainCode), .warpEn(warpEn),
    .lowHalfSel(lowHalfSel), .dacEn(dacEn), .fifoClr(fifoClr),
    .gainErr(gainErr)
  );

  always @(negedge clk) begin
    if (fifoClr) clrCycles++;
    if (gainErr) errCycles++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic shiftBit(input logic b);
    serData = b;
    serClk = 1'b0;
    repeat (4) @(negedge clk);
    serClk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic sendWord(input logic [23:0] w);
    clrCycles = 0;
    errCycles = 0;
    for (int i = 23; i >= 0; i--) shiftBit(w[i]);
    serClk = 1'b0;
    repeat (14) @(negedge clk);
  endtask

  task automatic checkOpts(input string req, input int w, input int l, input int d);
    check({req, " warpEn"}, warpEn, w);
    check({req, " lowHalfSel"}, lowHalfSel, l);
    check({req, " dacEn"}, dacEn, d);
  endtask

  task automatic tReset();
    check("R1 gainCode", gainCode, 0);
    checkOpts("R1", 0, 0, 0);
    check("R1 fifoClr", fifoClr, 0);
    check("R1 gainErr", gainErr, 0);
  endtask

  task automatic tGain();
    sendWord(24'h0D0005);
    check("R2 gainCode", gainCode, 5);
    check("R2 no error", errCycles, 0);
    sendWord(24'hFDFFF9);
    check("R8 unused bits ignored", gainCode, 9);
  endtask

  task automatic tForbidden();
    sendWord(24'h0D000F);
    check("R3 gain kept", gainCode, 9);
    check("R3 error cycles", errCycles, 1);
  endtask

  task automatic tOptions();
    sendWord(24'h0C0007);
    checkOpts("R4 all set", 1, 1, 1);
    check("R4 no clear", clrCycles, 0);
    sendWord(24'h0C0002);
    checkOpts("R4 overwrite", 0, 1, 0);
  endtask

  task automatic tClear();
    sendWord(24'h0C0009);
    check("R5 clear length", clrCycles, 4);
    checkOpts("R5 bits written", 1, 0, 0);
  endtask

  task automatic tOtherFn();
    sendWord(24'h0B0003);
    sendWord(24'h0E000E);
    check("R6 gain unchanged", gainCode, 9);
    checkOpts("R6", 1, 0, 0);
    check("R6 no clear", clrCycles, 0);
  endtask

  task automatic tFrame();
    for (int i = 0; i < 10; i++) shiftBit(1'b1);
    serClk = 1'b0;
    repeat (6) @(negedge clk);
    check("R7 partial no effect", gainCode, 9);
    serFrame = 1'b1;
    repeat (6) @(negedge clk);
    serFrame = 1'b0;
    repeat (4) @(negedge clk);
    sendWord(24'h0D0003);
    check("R7 realigned word", gainCode, 3);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    tReset();
    tGain();
    tForbidden();
    tOptions();
    tClear();
    tOtherFn();
    tFrame();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule